// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects up to `N` interrupt inputs for a small processor core and turns them into a single request with a jump address. Each input passes through a synchronizer and a per-input trigger detector. The detector can be set to fire on a rising edge, a falling edge, any change, a high level or a low level. A detected trigger latches a pending flag. The flag latches whether or not the input or the block as a whole is enabled, so software can also poll the flags.

Each input has an enable bit and a priority bit. Two handler levels exist, each with its own jump address. A high-level request can interrupt a running low-level handler, but a low-level request never interrupts a high-level handler. Entering a handler masks its own level and every level below it. A return strobe ends the most recently entered level. When the two-level mode is switched off, every input is served at the high level and handlers do not nest.

Software reaches the flags, enables, priorities, control bits and trigger modes through a simple word-wide register port. Writes take effect on the clock edge and reads are combinational.

Top module: `irq2_ctrl`

## Requirements
- R1: Each input has a 3-bit trigger mode in the MODE register (address 4), at bits [3i+2:3i]. The codes are 0 rising edge, 1 falling edge, 2 either edge, 3 high level, 4 low level; codes 5 to 7 never trigger. A trigger sets the flag on the third rising clock edge after the input changes.
- R2: A trigger sets the input's flag (FLAG register, address 0, bit i) regardless of its enable bit and of the global enable.
- R3: `irq_req` is raised only when some flag is set and that input's enable bit (ENABLE, address 1) is set and global enable (CTRL address 3, bit 0) is set. A flag left pending while disabled raises a request as soon as it becomes enabled.
- R4: With two-level mode on (CTRL bit 1), an input whose PRIO bit (address 2) is 1 is high level and vectors to 0x08; a PRIO bit of 0 means low level, which vectors to 0x18.
- R5: While a low-level handler runs, a pending enabled high-level input raises a request with vector 0x08. While a high-level handler runs, no low-level request is raised.
- R6: When `irq_ack` is pulsed while `irq_req` is high, the level shown on `irq_vector` becomes active, and requests of that level and below are masked until a return.
- R7: Entering a handler does not clear any flag; flags stay readable until software clears them.
- R8: With two-level mode off, every enabled input vectors to 0x08 and no second request is raised while a handler runs.
- R9: `irq_ret` ends the most recently entered level. Returning from a high-level handler that preempted a low one leaves the low level active.
- R10: Writing 1 to a FLAG bit clears it. A trigger in the same cycle as the clear keeps the flag set, so a level-mode input that is still active sets its flag again.
- R11: After reset all flags, enables, priorities, control bits and modes are 0 and `irq_req` is low. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N | Raw interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 3*N | Register write data |
| reg_rdata | output | 3*N | Register read data (combinational) |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | VW | Jump address of the requested level |
| irq_ack | input | 1 | Core enters the requested handler |
| irq_ret | input | 1 | Return from the current handler |

## Verification
The assertions assume that the core pulses `irq_ack` only while `irq_req` is high and never in the same cycle as `irq_ret`. They also assume that `irq_ret` arrives only while a handler level is active. The stimulus drives both strobes as single-cycle pulses, each after sampling the request, and issues every return against a handler it entered itself. Raw inputs are held for several cycles so that every change passes through the synchronizer before the next one.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  typedef enum logic [2:0] {
    SENS_RISE = 3'd0,
    SENS_FALL = 3'd1,
    SENS_ANY  = 3'd2,
    SENS_HIGH = 3'd3,
    SENS_LOW  = 3'd4
  } sens_e;

  localparam logic [2:0] ADDR_FLAG = 3'd0;
  localparam logic [2:0] ADDR_EN   = 3'd1;
  localparam logic [2:0] ADDR_PRIO = 3'd2;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_MODE = 3'd4;
endpackage

// File: rtl/irq2_detect.sv
module irq2_detect
  import irq2_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_in,
  input  logic [2:0] mode,
  output logic       trig
);
  logic [SYNC-1:0] sync_q, sync_d;
  logic            prev_q;
  logic            cur;

  assign cur = sync_q[SYNC-1];

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], src_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= cur;
    end
  end

  always_comb begin
    case (mode)
      SENS_RISE: trig = cur & ~prev_q;
      SENS_FALL: trig = ~cur & prev_q;
      SENS_ANY:  trig = cur ^ prev_q;
      SENS_HIGH: trig = cur;
      SENS_LOW:  trig = ~cur;
      default:   trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq2_regs.sv
module irq2_regs
  import irq2_pkg::*;
#(
  parameter int N = 8,
  localparam int DW = 3 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  trig,
  output logic [N-1:0]  flag,
  output logic [N-1:0]  en,
  output logic [N-1:0]  prio,
  output logic          gie,
  output logic          pmode,
  output logic [DW-1:0] modes
);
  logic [N-1:0]  flag_q, flag_d, clr;
  logic [N-1:0]  en_q, prio_q;
  logic [1:0]    ctrl_q;
  logic [DW-1:0] mode_q;
  logic          en_we, prio_we, ctrl_we, mode_we;

  always_comb begin
    en_we   = we && (addr == ADDR_EN);
    prio_we = we && (addr == ADDR_PRIO);
    ctrl_we = we && (addr == ADDR_CTRL);
    mode_we = we && (addr == ADDR_MODE);
    clr     = (we && (addr == ADDR_FLAG)) ? wdata[N-1:0] : '0;
    flag_d  = (flag_q & ~clr) | trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we)   en_q   <= wdata[N-1:0];
      if (prio_we) prio_q <= wdata[N-1:0];
      if (ctrl_we) ctrl_q <= wdata[1:0];
      if (mode_we) mode_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      ADDR_FLAG: rdata = {{(DW-N){1'b0}}, flag_q};
      ADDR_EN:   rdata = {{(DW-N){1'b0}}, en_q};
      ADDR_PRIO: rdata = {{(DW-N){1'b0}}, prio_q};
      ADDR_CTRL: rdata = {{(DW-2){1'b0}}, ctrl_q};
      ADDR_MODE: rdata = mode_q;
      default:   rdata = '0;
    endcase
  end

  assign flag  = flag_q;
  assign en    = en_q;
  assign prio  = prio_q;
  assign gie   = ctrl_q[0];
  assign pmode = ctrl_q[1];
  assign modes = mode_q;

  AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(trig)) == $past(trig)));  // R2
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));  // R7
endmodule

// File: rtl/irq2_nest.sv
module irq2_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_pend,
  input  logic lo_pend,
  input  logic ack,
  input  logic ret,
  output logic req,
  output logic take_hi
);
  logic hi_act_q, lo_act_q, hi_act_d, lo_act_d;
  logic hi_ok, lo_ok, ack_hi, ack_lo, ret_hi, ret_lo;

  always_comb begin
    hi_ok    = hi_pend & ~hi_act_q;
    lo_ok    = lo_pend & ~hi_act_q & ~lo_act_q;
    req      = hi_ok | lo_ok;
    take_hi  = hi_ok;
    ack_hi   = ack & req & take_hi;
    ack_lo   = ack & req & ~take_hi;
    ret_hi   = ret & hi_act_q;
    ret_lo   = ret & ~hi_act_q & lo_act_q;
    hi_act_d = (hi_act_q & ~ret_hi) | ack_hi;
    lo_act_d = (lo_act_q & ~ret_lo) | ack_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_act_q <= 1'b0;
      lo_act_q <= 1'b0;
    end else begin
      hi_act_q <= hi_act_d;
      lo_act_q <= lo_act_d;
    end
  end

  AST_HI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req && take_hi) |=> hi_act_q);  // R6
  AST_LO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req && !take_hi) |=> lo_act_q);  // R6
  AST_HI_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_act_q |-> !(req && !take_hi));  // R5
  AST_RET_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && hi_act_q) |=> !hi_act_q);  // R9
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && hi_act_q && lo_act_q) |=> lo_act_q);  // R9
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl #(
  parameter int         N      = 8,
  parameter int         SYNC   = 2,
  parameter int         VW     = 8,
  parameter logic [7:0] HI_VEC = 8'h08,
  parameter logic [7:0] LO_VEC = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_in,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [3*N-1:0]   reg_wdata,
  output logic [3*N-1:0]   reg_rdata,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vector,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  localparam int DW = 3 * N;

  logic [N-1:0]  trig, flag, en, prio, hi_sel, lo_sel;
  logic [DW-1:0] modes;
  logic          gie, pmode, hi_pend, lo_pend, take_hi;

  for (genvar i = 0; i < N; i++) begin : g_src
    irq2_detect #(.SYNC(SYNC)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_in (src_in[i]),
      .mode   (modes[3*i +: 3]),
      .trig   (trig[i])
    );
  end

  irq2_regs #(.N(N)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .trig  (trig),
    .flag  (flag),
    .en    (en),
    .prio  (prio),
    .gie   (gie),
    .pmode (pmode),
    .modes (modes)
  );

  always_comb begin
    hi_sel  = flag & en & (pmode ? prio : {N{1'b1}});
    lo_sel  = flag & en & ~prio;
    hi_pend = gie & (|hi_sel);
    lo_pend = gie & pmode & (|lo_sel);
  end

  irq2_nest u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_pend (hi_pend),
    .lo_pend (lo_pend),
    .ack     (irq_ack),
    .ret     (irq_ret),
    .req     (irq_req),
    .take_hi (take_hi)
  );

  assign irq_vector = VW'(take_hi ? HI_VEC : LO_VEC);

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);  // R3
  AST_FLAT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmode && irq_req) |-> (irq_vector == VW'(HI_VEC)));  // R8
endmodule

// File: tb/irq2_ctrl_tb.sv
module irq2_ctrl_tb;
  localparam int N  = 8;
  localparam int DW = 3 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_req;
  logic [7:0]    irq_vector;
  logic          irq_ack = 1'b0;
  logic          irq_ret = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] mode_sh = '0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  irq2_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .irq_ret(irq_ret)
  );

  // {mode[2:0], level before, level after, expected flag}
  localparam logic [5:0] TBL [16] = '{
    {3'd0,1'b0,1'b1,1'b1}, {3'd0,1'b1,1'b0,1'b0}, {3'd0,1'b1,1'b1,1'b0},
    {3'd1,1'b1,1'b0,1'b1}, {3'd1,1'b0,1'b1,1'b0},
    {3'd2,1'b0,1'b1,1'b1}, {3'd2,1'b1,1'b0,1'b1}, {3'd2,1'b0,1'b0,1'b0},
    {3'd3,1'b0,1'b1,1'b1}, {3'd3,1'b0,1'b0,1'b0}, {3'd3,1'b1,1'b0,1'b1},
    {3'd4,1'b1,1'b1,1'b0}, {3'd4,1'b1,1'b0,1'b1}, {3'd4,1'b0,1'b1,1'b1},
    {3'd5,1'b0,1'b1,1'b0}, {3'd7,1'b1,1'b0,1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); src_in[idx] = 1'b1; settle(6);
    src_in[idx] = 1'b0; settle(6);
  endtask

  task automatic strobe_ack();
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic strobe_ret();
    @(negedge clk); irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    // R11 reset state
    rd(3'd0, rv); chk(rv, 0, "R11 flags after reset");
    rd(3'd3, rv); chk(rv, 0, "R11 ctrl after reset");
    rd(3'd4, rv); chk(rv, 0, "R11 modes after reset");
    rd(3'd6, rv); chk(rv, 0, "R11 unmapped read");
    chk(irq_req, 0, "R11 no request after reset");

    // R1 trigger modes on input 0, table walk
    for (int k = 0; k < 16; k++) begin
      mode_sh[2:0] = TBL[k][5:3];
      wr(3'd4, mode_sh);
      src_in[0] = TBL[k][2];
      settle(6);
      wr(3'd0, DW'(1));
      src_in[0] = TBL[k][1];
      settle(6);
      rd(3'd0, rv);
      chk(rv[0], TBL[k][0], $sformatf("R1 mode table entry %0d", k));
    end
    mode_sh[2:0] = 3'd0;
    wr(3'd4, mode_sh);
    src_in[0] = 1'b0;
    settle(6);
    wr(3'd0, '1);

    // R1 latency: flag appears on third edge after change
    @(negedge clk); src_in[4] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(3'd0, rv); chk(rv[4], 0, "R1 flag not yet after two edges");
    settle(1);
    rd(3'd0, rv); chk(rv[4], 1, "R1 flag after third edge");
    src_in[4] = 1'b0; settle(6); wr(3'd0, '1);

    // R2 / R3: flag latches while disabled, request once enabled
    pulse(1);
    rd(3'd0, rv); chk(rv[1], 1, "R2 flag set while disabled");
    chk(irq_req, 0, "R3 no request while disabled");
    wr(3'd1, DW'(8'h06));
    chk(irq_req, 0, "R3 no request without global enable");
    wr(3'd3, DW'(2'b01));
    chk(irq_req, 1, "R3 pending flag requests once enabled");
    chk(irq_vector, 8'h08, "R8 flat mode vector");
    strobe_ack();
    chk(irq_req, 0, "R6 same level masked after entry");
    rd(3'd0, rv); chk(rv[1], 1, "R7 flag kept after entry");
    wr(3'd0, DW'(8'h02));
    strobe_ret();
    chk(irq_req, 0, "R3 no request after flag cleared");

    // R4 / R5 / R9: two-level mode
    wr(3'd2, DW'(8'h04));
    wr(3'd3, DW'(2'b11));
    pulse(1);
    chk(irq_req, 1, "R4 low request");
    chk(irq_vector, 8'h18, "R4 low vector");
    strobe_ack();
    chk(irq_req, 0, "R6 low masked in low handler");
    pulse(2);
    chk(irq_req, 1, "R5 high preempts low");
    chk(irq_vector, 8'h08, "R4 high vector");
    strobe_ack();
    chk(irq_req, 0, "R5 low not taken in high handler");
    wr(3'd0, DW'(8'h04));
    strobe_ret();
    chk(irq_req, 0, "R9 low level still active after high return");
    strobe_ret();
    chk(irq_req, 1, "R9 low request after low return");
    chk(irq_vector, 8'h18, "R9 low vector after returns");
    wr(3'd0, DW'(8'h02));
    chk(irq_req, 0, "R10 cleared flag drops request");

    // R8: flat mode, no nesting
    wr(3'd3, DW'(2'b01));
    pulse(1);
    chk(irq_vector, 8'h08, "R8 low-prio input uses high vector");
    strobe_ack();
    pulse(2);
    chk(irq_req, 0, "R8 no nesting in flat mode");
    strobe_ret();
    chk(irq_req, 1, "R8 request after return");
    wr(3'd0, '1);
    chk(irq_req, 0, "R10 all flags cleared");

    // R10: clear races a level trigger
    mode_sh[11:9] = 3'd3;
    wr(3'd4, mode_sh);
    @(negedge clk); src_in[3] = 1'b1; settle(6);
    wr(3'd0, DW'(8'h08));
    rd(3'd0, rv); chk(rv[3], 1, "R10 trigger wins over clear");
    src_in[3] = 1'b0; settle(6);
    wr(3'd0, DW'(8'h08));
    rd(3'd0, rv); chk(rv[3], 0, "R10 clear with inactive level");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule